// File: doc/BRIEF.md
# Three-Phase Tamper Condition Detector

This block watches one frame of signed 12-bit samples at a time: three phase voltages and three phase currents, delivered together under a sample-valid strobe. It looks for two kinds of tampering. The first is a lost voltage phase. Over each line cycle, the block tracks the largest sample magnitude of each voltage phase and whether that phase went both positive and negative. When the line-cycle strobe arrives, a phase whose peak stayed under a tenth of full scale, or which never changed sign, is reported as missing.

The second kind is unbalance. On every valid frame, the block forms the instantaneous sum of the three voltages and, separately, the sum of the three currents. If the magnitude of a sum is larger than half of its programmed 16-bit level, the matching unbalance flag is set.

Every flag is sticky. The host clears a flag by writing a one to its bit on the clear port. A single interrupt line combines the enabled flags. A line cycle is 100 frames by default, but the block does not count frames: it acts on the line-cycle strobe.

Top module: `tamper_detect`

## Requirements
- R1: After reset, all missing-phase flags, the summary flag, both unbalance flags and `irq` are 0.
- R2: At a line-cycle strobe, a voltage phase is flagged missing if the largest absolute sample it delivered since the previous strobe (or since reset) is below 205 LSB. A peak of exactly 205 counts as present. A sample of -2048 counts as magnitude 2048.
- R3: At a line-cycle strobe, a voltage phase is also flagged missing unless, since the previous strobe, it delivered at least one sample above zero and at least one sample below zero. A zero sample counts as neither.
- R4: Missing-phase flags change only on the clock edge that samples `cycleStrobe`, and are visible in the following cycle. A frame that is valid in the same cycle as the strobe belongs to the new line cycle.
- R5: `missAny` is 1 exactly when at least one bit of `missPhase` is 1.
- R6: On a valid frame, `vUnbFlag` is set on the next edge when 2·|vA+vB+vC| > `vUnbLevel`. Equality does not set the flag. The sum is exact over the whole input range, including 3·(-2048).
- R7: On a valid frame, `iUnbFlag` is set on the next edge when 2·|iA+iB+iC| > `iUnbLevel`. Equality does not set the flag. The sum is exact over the whole input range.
- R8: Flags hold until cleared. In `clearBits`, bits 0, 1 and 2 clear the missing flags of phases A, B and C, bit 3 clears `vUnbFlag`, and bit 4 clears `iUnbFlag`. A clear and a set of the same flag in the same cycle leave the flag set.
- R9: `irq` is the OR of (`missAny` AND `missIrqEn`), (`vUnbFlag` AND `vUnbIrqEn`) and (`iUnbFlag` AND `iUnbIrqEn`). It follows the flags in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleValid | input | 1 | Frame of six samples is valid this cycle |
| vA | input | 12 | Phase A voltage sample, signed |
| vB | input | 12 | Phase B voltage sample, signed |
| vC | input | 12 | Phase C voltage sample, signed |
| iA | input | 12 | Phase A current sample, signed |
| iB | input | 12 | Phase B current sample, signed |
| iC | input | 12 | Phase C current sample, signed |
| cycleStrobe | input | 1 | End of line cycle; missing-phase decision point |
| vUnbLevel | input | 16 | Voltage unbalance level (compared against twice the sum magnitude) |
| iUnbLevel | input | 16 | Current unbalance level (compared against twice the sum magnitude) |
| missIrqEn | input | 1 | Lets the summary missing flag drive `irq` |
| vUnbIrqEn | input | 1 | Lets the voltage unbalance flag drive `irq` |
| iUnbIrqEn | input | 1 | Lets the current unbalance flag drive `irq` |
| clearBits | input | 5 | Write-one-to-clear pulses for the five flags |
| missPhase | output | 3 | Sticky missing flags, bit 0 = phase A |
| missAny | output | 1 | Summary missing flag |
| vUnbFlag | output | 1 | Sticky voltage unbalance flag |
| iUnbFlag | output | 1 | Sticky current unbalance flag |
| irq | output | 1 | Interrupt request |

## Verification
The assertions depend on the input contract. Samples are trusted only while `sampleValid` is high, and `cycleStrobe` is the only event that can raise a missing flag. Under that contract, an unbalance flag can rise only after a valid frame, and a missing flag only after a strobe. The stimulus applies each frame for exactly one cycle and the strobe as a separate one-cycle pulse. In one directed case it deliberately merges a frame with the strobe to check R4. Levels are driven to the 16-bit maximum while missing-phase cases run, so unbalance cannot interfere with those checks.

// File: rtl/tamper_pkg.sv
package tamper_pkg;
  typedef struct packed {
    logic take;     // a frame is valid this cycle
    logic restart;  // close the line cycle and start a new one
  } dpStrobe_t;

  localparam int FLAG_W = 5;
  localparam int F_VUNB = 3;
  localparam int F_IUNB = 4;
endpackage

// File: rtl/tamper_datapath.sv
module tamper_datapath
  import tamper_pkg::*;
#(
  parameter int SW       = 12,
  parameter int LW       = 16,
  parameter int PHASES   = 3,
  parameter int LOW_PEAK = 205
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  dpStrobe_t            strb,
  input  logic [PHASES*SW-1:0] vBus,
  input  logic [PHASES*SW-1:0] iBus,
  input  logic [LW-1:0]        vLevel,
  input  logic [LW-1:0]        iLevel,
  output logic [PHASES-1:0]    missVerdict,
  output logic                 vUnbHit,
  output logic                 iUnbHit
);
  localparam int PEAK_W = SW + 1;
  localparam int SUM_W  = SW + $clog2(PHASES);
  localparam int CMP_W  = ((SUM_W + 1 > LW) ? SUM_W + 1 : LW) + 1;

  // Per-phase peak magnitude and sign-seen trackers
  for (genvar p = 0; p < PHASES; p++) begin : g_phase
    logic [SW-1:0]     smp;
    logic [PEAK_W-1:0] mag;
    logic [PEAK_W-1:0] peakQ;
    logic              posQ, negQ;
    logic              isPos, isNeg;

    assign smp   = vBus[p*SW +: SW];
    assign isNeg = smp[SW-1];
    assign isPos = !smp[SW-1] && (smp != '0);
    assign mag   = isNeg ? (~{smp[SW-1], smp} + 1'b1) : {1'b0, smp};

    always_ff @(posedge clk) begin
      if (!rstN) begin
        peakQ <= '0;
        posQ  <= 1'b0;
        negQ  <= 1'b0;
      end else if (strb.restart) begin
        peakQ <= strb.take ? mag : '0;
        posQ  <= strb.take && isPos;
        negQ  <= strb.take && isNeg;
      end else if (strb.take) begin
        if (mag > peakQ) peakQ <= mag;
        posQ <= posQ | isPos;
        negQ <= negQ | isNeg;
      end
    end

    assign missVerdict[p] = (peakQ < PEAK_W'(LOW_PEAK)) || !(posQ && negQ);

    // R2: the tracked peak never exceeds full-scale magnitude
    a_r2_peak_bound: assert property (@(posedge clk) disable iff (!rstN)
      peakQ <= PEAK_W'(1 << (SW - 1)));
  end

  // Instantaneous three-phase sums and their magnitudes
  logic signed [SUM_W-1:0] vSum, iSum;
  logic [SUM_W-1:0]        vMag, iMag;

  always_comb begin
    vSum = '0;
    iSum = '0;
    for (int p = 0; p < PHASES; p++) begin
      vSum += SUM_W'($signed(vBus[p*SW +: SW]));
      iSum += SUM_W'($signed(iBus[p*SW +: SW]));
    end
  end

  assign vMag = vSum[SUM_W-1] ? (~vSum + 1'b1) : vSum;
  assign iMag = iSum[SUM_W-1] ? (~iSum + 1'b1) : iSum;

  assign vUnbHit = CMP_W'({vMag, 1'b0}) > CMP_W'(vLevel);
  assign iUnbHit = CMP_W'({iMag, 1'b0}) > CMP_W'(iLevel);
endmodule

// File: rtl/tamper_ctrl.sv
module tamper_ctrl
  import tamper_pkg::*;
#(
  parameter int PHASES = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sampleValid,
  input  logic              cycleStrobe,
  input  logic [FLAG_W-1:0] clearBits,
  input  logic [PHASES-1:0] missVerdict,
  input  logic              vUnbHit,
  input  logic              iUnbHit,
  input  logic              missIrqEn,
  input  logic              vUnbIrqEn,
  input  logic              iUnbIrqEn,
  output dpStrobe_t         strb,
  output logic [FLAG_W-1:0] flags,
  output logic              irq
);
  logic [FLAG_W-1:0] flagsQ, setVec;

  assign strb.take    = sampleValid;
  assign strb.restart = cycleStrobe;

  always_comb begin
    setVec                     = '0;
    setVec[PHASES-1:0]         = missVerdict & {PHASES{cycleStrobe}};
    setVec[F_VUNB]             = vUnbHit && sampleValid;
    setVec[F_IUNB]             = iUnbHit && sampleValid;
  end

  always_ff @(posedge clk) begin
    if (!rstN) flagsQ <= '0;
    else       flagsQ <= (flagsQ & ~clearBits) | setVec;
  end

  assign flags = flagsQ;
  assign irq   = (missIrqEn && (|flagsQ[PHASES-1:0]))
               | (vUnbIrqEn && flagsQ[F_VUNB])
               | (iUnbIrqEn && flagsQ[F_IUNB]);

  // R4: no missing flag rises unless the previous cycle carried the strobe
  a_r4_miss_only_at_strobe: assert property (@(posedge clk) disable iff (!rstN)
    !cycleStrobe |=> ((flagsQ[PHASES-1:0] & ~$past(flagsQ[PHASES-1:0])) == '0));

  // R6: the voltage unbalance flag rises only after a valid frame
  a_r6_vunb_needs_frame: assert property (@(posedge clk) disable iff (!rstN)
    !sampleValid |=> !$rose(flagsQ[F_VUNB]));

  // R8: with no clear pulse, no flag falls
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (clearBits == '0) |=> (($past(flagsQ) & ~flagsQ) == '0));

  // R8: a current unbalance clear without a competing frame empties the flag
  a_r8_clear_iunb: assert property (@(posedge clk) disable iff (!rstN)
    (clearBits[F_IUNB] && !sampleValid) |=> !flagsQ[F_IUNB]);
endmodule

// File: rtl/tamper_detect.sv
module tamper_detect
  import tamper_pkg::*;
#(
  parameter int SW       = 12,
  parameter int LW       = 16,
  parameter int LOW_PEAK = 205
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          sampleValid,
  input  logic [SW-1:0] vA,
  input  logic [SW-1:0] vB,
  input  logic [SW-1:0] vC,
  input  logic [SW-1:0] iA,
  input  logic [SW-1:0] iB,
  input  logic [SW-1:0] iC,
  input  logic          cycleStrobe,
  input  logic [LW-1:0] vUnbLevel,
  input  logic [LW-1:0] iUnbLevel,
  input  logic          missIrqEn,
  input  logic          vUnbIrqEn,
  input  logic          iUnbIrqEn,
  input  logic [4:0]    clearBits,
  output logic [2:0]    missPhase,
  output logic          missAny,
  output logic          vUnbFlag,
  output logic          iUnbFlag,
  output logic          irq
);
  localparam int PHASES = 3;

  dpStrobe_t           strb;
  logic [PHASES-1:0]   missVerdict;
  logic                vUnbHit, iUnbHit;
  logic [FLAG_W-1:0]   flags;

  tamper_datapath #(
    .SW(SW), .LW(LW), .PHASES(PHASES), .LOW_PEAK(LOW_PEAK)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .vBus({vC, vB, vA}), .iBus({iC, iB, iA}),
    .vLevel(vUnbLevel), .iLevel(iUnbLevel),
    .missVerdict(missVerdict), .vUnbHit(vUnbHit), .iUnbHit(iUnbHit)
  );

  tamper_ctrl #(.PHASES(PHASES)) u_ctrl (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .cycleStrobe(cycleStrobe),
    .clearBits(clearBits), .missVerdict(missVerdict),
    .vUnbHit(vUnbHit), .iUnbHit(iUnbHit),
    .missIrqEn(missIrqEn), .vUnbIrqEn(vUnbIrqEn), .iUnbIrqEn(iUnbIrqEn),
    .strb(strb), .flags(flags), .irq(irq)
  );

  assign missPhase = flags[PHASES-1:0];
  assign missAny   = |flags[PHASES-1:0];
  assign vUnbFlag  = flags[F_VUNB];
  assign iUnbFlag  = flags[F_IUNB];
endmodule

// File: tb/tb_tamper_detect.sv
module tb_tamper_detect;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sampleValid = 1'b0, cycleStrobe = 1'b0;
  logic signed [11:0] vA = '0, vB = '0, vC = '0, iA = '0, iB = '0, iC = '0;
  logic [15:0] vUnbLevel = 16'hFFFF, iUnbLevel = 16'hFFFF;
  logic missIrqEn = 1'b0, vUnbIrqEn = 1'b0, iUnbIrqEn = 1'b0;
  logic [4:0] clearBits = '0;
  logic [2:0] missPhase;
  logic missAny, vUnbFlag, iUnbFlag, irq;

  int nChecks = 0, nFails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tamper_detect dut (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid),
    .vA(vA), .vB(vB), .vC(vC), .iA(iA), .iB(iB), .iC(iC),
    .cycleStrobe(cycleStrobe), .vUnbLevel(vUnbLevel), .iUnbLevel(iUnbLevel),
    .missIrqEn(missIrqEn), .vUnbIrqEn(vUnbIrqEn), .iUnbIrqEn(iUnbIrqEn),
    .clearBits(clearBits), .missPhase(missPhase), .missAny(missAny),
    .vUnbFlag(vUnbFlag), .iUnbFlag(iUnbFlag), .irq(irq)
  );

  typedef struct packed {
    logic signed [11:0] va, vb, vc, ia, ib, ic;
    logic [15:0] vl, il;
    logic ev, ei;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{12'sd100, -12'sd50, -12'sd50, 12'sd0, 12'sd0, 12'sd0, 16'd10, 16'd10, 1'b0, 1'b0},
    '{12'sd10, 12'sd0, 12'sd0, 12'sd0, 12'sd0, 12'sd0, 16'd19, 16'd0, 1'b1, 1'b0},
    '{12'sd10, 12'sd0, 12'sd0, 12'sd0, 12'sd0, -12'sd6, 16'd20, 16'd11, 1'b0, 1'b1},
    '{-12'sd2048, -12'sd2048, -12'sd2048, 12'sd2047, 12'sd2047, 12'sd2047, 16'd65535, 16'd12281, 1'b0, 1'b1},
    '{-12'sd2048, -12'sd2048, -12'sd2048, 12'sd2047, 12'sd2047, 12'sd2047, 16'd12287, 16'd12282, 1'b1, 1'b0},
    '{12'sd2047, -12'sd2048, 12'sd0, -12'sd1000, 12'sd500, 12'sd500, 16'd1, 16'd0, 1'b1, 1'b0},
    '{12'sd1000, 12'sd1000, -12'sd1999, 12'sd300, 12'sd300, 12'sd300, 16'd2, 16'd1799, 1'b0, 1'b1},
    '{12'sd0, 12'sd0, 12'sd1, 12'sd0, 12'sd0, 12'sd0, 16'd0, 16'd65535, 1'b1, 1'b0}
  };

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic frame(input int a, input int b, input int c,
                       input int x, input int y, input int z);
    @(negedge clk);
    vA = 12'(a); vB = 12'(b); vC = 12'(c);
    iA = 12'(x); iB = 12'(y); iC = 12'(z);
    sampleValid = 1'b1;
    @(negedge clk);
    sampleValid = 1'b0;
  endtask

  task automatic clearAll();
    @(negedge clk) clearBits = 5'h1F;
    @(negedge clk) clearBits = 5'h00;
  endtask

  task automatic strobe();
    @(negedge clk) cycleStrobe = 1'b1;
    @(negedge clk) cycleStrobe = 1'b0;
  endtask

  // mode 0: alternating sign, 1: positive only, 2: negative only, 3: alternating with zeros
  function automatic int wave(input int amp, input int mode, input int k);
    case (mode)
      0: return (k % 2 == 1) ? -amp : amp;
      1: return amp;
      2: return -amp;
      default: return (k % 2 == 1) ? 0 : ((k % 4 == 0) ? amp : -amp);
    endcase
  endfunction

  task automatic lineCycle(input int aA, input int mA, input int aB, input int mB,
                           input int aC, input int mC);
    for (int k = 0; k < 8; k++)
      frame(wave(aA, mA, k), wave(aB, mB, k), wave(aC, mC, k), 0, 0, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    if (!done) $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 flags", {missPhase, missAny, vUnbFlag, iUnbFlag}, 0);
    check("R1 irq", irq, 0);
    @(negedge clk) rstN = 1'b1;

    // R6/R7: unbalance vector table
    for (int n = 0; n < NV; n++) begin
      clearAll();
      @(negedge clk);
      vUnbLevel = VECS[n].vl; iUnbLevel = VECS[n].il;
      vA = VECS[n].va; vB = VECS[n].vb; vC = VECS[n].vc;
      iA = VECS[n].ia; iB = VECS[n].ib; iC = VECS[n].ic;
      sampleValid = 1'b1;
      @(negedge clk) sampleValid = 1'b0;
      check($sformatf("R6 vec%0d", n), vUnbFlag, VECS[n].ev);
      check($sformatf("R7 vec%0d", n), iUnbFlag, VECS[n].ei);
    end
    @(negedge clk) begin vUnbLevel = 16'hFFFF; iUnbLevel = 16'hFFFF; end

    // R2: peak threshold 204 missing, 205 present, 2047 present
    strobe(); clearAll();
    lineCycle(204, 0, 205, 0, 2047, 0);
    strobe();
    check("R2 peak threshold", missPhase, 3'b001);
    check("R5 summary set", missAny, 1);
    missIrqEn = 1'b1; #1;
    check("R9 irq miss enabled", irq, 1);
    missIrqEn = 1'b0; #1;
    check("R9 irq miss disabled", irq, 0);

    // R2: -2048 counts as full magnitude
    strobe(); clearAll();
    for (int k = 0; k < 4; k++) frame(-2048, -2048, -2048, 0, 0, 0);
    frame(1, 1, 1, 0, 0, 0);
    strobe();
    check("R2 neg full scale", missPhase, 3'b000);

    // R3: one-sided waveforms missing; zeros mixed with both signs present
    strobe(); clearAll();
    lineCycle(1000, 1, 1000, 2, 1000, 3);
    strobe();
    check("R3 no crossing", missPhase, 3'b011);
    // R8: clear phase A only
    @(negedge clk) clearBits = 5'b00001;
    @(negedge clk) clearBits = 5'b00000;
    check("R8 clear phase A", missPhase, 3'b010);
    check("R5 summary still set", missAny, 1);
    clearAll();
    check("R5 summary clear", missAny, 0);

    // R4: no decision before the strobe; frame with the strobe opens the new cycle
    strobe(); clearAll();
    lineCycle(1000, 1, 1000, 1, 1000, 1);
    check("R4 no decision before strobe", missPhase, 3'b000);
    @(negedge clk);
    vA = -12'sd1000; vB = -12'sd1000; vC = -12'sd1000;
    iA = '0; iB = '0; iC = '0;
    sampleValid = 1'b1; cycleStrobe = 1'b1;
    @(negedge clk) begin sampleValid = 1'b0; cycleStrobe = 1'b0; end
    check("R4 decision at strobe", missPhase, 3'b111);
    clearAll();
    lineCycle(1000, 1, 1000, 1, 1000, 1);
    strobe();
    check("R4 strobe frame in new cycle", missPhase, 3'b000);

    // R8: set wins over clear; sticky; bits are independent
    clearAll();
    @(negedge clk);
    vUnbLevel = 16'd0;
    vA = 12'sd10; vB = '0; vC = '0; iA = '0; iB = '0; iC = '0;
    sampleValid = 1'b1; clearBits = 5'b01000;
    @(negedge clk) begin sampleValid = 1'b0; clearBits = 5'b00000; end
    check("R8 set wins", vUnbFlag, 1);
    @(negedge clk) vUnbLevel = 16'hFFFF;
    frame(0, 0, 0, 0, 0, 0);
    check("R8 sticky", vUnbFlag, 1);
    vUnbIrqEn = 1'b1; #1;
    check("R9 irq vunb", irq, 1);
    vUnbIrqEn = 1'b0; #1;
    check("R9 irq vunb masked", irq, 0);
    @(negedge clk) clearBits = 5'b10000;
    @(negedge clk) clearBits = 5'b00000;
    check("R8 other bit no effect", vUnbFlag, 1);
    @(negedge clk) clearBits = 5'b01000;
    @(negedge clk) clearBits = 5'b00000;
    check("R8 clear vunb", vUnbFlag, 0);

    // R7/R9: current unbalance drives irq when enabled
    @(negedge clk) iUnbLevel = 16'd0;
    frame(0, 0, 0, 5, 0, 0);
    iUnbIrqEn = 1'b1; #1;
    check("R7 iunb set", iUnbFlag, 1);
    check("R9 irq iunb", irq, 1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule